// File: doc/BRIEF.md
# MOVX Data-Space Router with On-Chip Auxiliary RAM

This block sits beside an 8051-style core and serves every external-data-space (MOVX) read and write. For each request it picks a target. One target is a 1 KB on-chip auxiliary RAM. The other is a simple external memory bus built from a low address/data port, a high address port, and active-low read and write strobes. It raises a one-cycle `done` pulse when the access completes, so the core can stall until then. Read data is valid in the same cycle as `done`.

The request carries a mode flag. In pointer mode the full 16-bit address comes from the data pointer. In register mode only the low byte comes from an index register. The high bits for an on-chip register-mode access come from a high-address register held inside the block. A control register, also held inside the block, can switch the auxiliary RAM off; bit 1 of that register disables it. While the RAM is off, every access goes out on the external bus. In register mode the high address byte is then taken from the current port-2 latch.

The router state machine has three states:
- `RT_IDLE` waits for a request.
- `RT_RAM` is the one-cycle completion of an on-chip access.
- `RT_EXT` waits for the bus master.

Its transitions are:
- `RT_IDLE`→`RT_RAM` on an on-chip request.
- `RT_IDLE`→`RT_EXT` on an external request.
- `RT_RAM`→`RT_IDLE` unconditionally.
- `RT_EXT`→`RT_IDLE` when the bus master reports done.

The bus master has three states:
- `BM_IDLE` waits for a start.
- `BM_SETUP` drives the address for one clock.
- `BM_STROBE` holds the strobe low for `STRB_CYC` clocks.

Its transitions are:
- `BM_IDLE`→`BM_SETUP` on start.
- `BM_SETUP`→`BM_STROBE` unconditionally.
- `BM_STROBE`→`BM_IDLE` after the last strobe clock.

Top module: `xdata_router`

## Requirements
- R1: After reset the control register is 0x00, so the auxiliary RAM is enabled and a register-mode access completes on chip with no strobe activity.
- R2: With the RAM enabled, a pointer-mode access at address 0x03FF or below reads and writes the auxiliary RAM at the address's low 10 bits.
- R3: A pointer-mode access at address 0x0400 or above always runs on the external bus, whether the RAM is enabled or not.
- R4: With the RAM enabled, a register-mode access always targets the auxiliary RAM at address {hi[1:0], Ri}. Bits 7..2 of the high-address register have no effect.
- R5: When control bit 1 is 1, every access goes external. A register-mode access then drives the port-2 latch value on `ext_p2` and Ri on `ext_p0`. Clearing the bit restores the RAM and its contents.
- R6: During an on-chip access, `ext_p0`, `ext_p0_oe`, `ext_p2`, `ext_rd_n` and `ext_wr_n` keep their previous values.
- R7: An on-chip access raises `done` exactly one clock after the request is sampled, with read data valid on `rdata` in that cycle.
- R8: An external access drives {`ext_p2`,`ext_p0`} = address for one setup clock. It then holds the selected strobe low for `STRB_CYC` clocks. Read data on `ext_p0_in` is captured as the strobe rises, and `done` is high in the following cycle, `STRB_CYC`+2 clocks after the request.
- R9: During a write strobe, `ext_p0` carries the write data with `ext_p0_oe` high and `ext_rd_n` stays high. During a read strobe, `ext_p0_oe` is low and `ext_wr_n` stays high.
- R10: `done` is a single-cycle pulse.
- R11: `ext_rd_n` and `ext_wr_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | MOVX request, sampled while idle |
| use_ri | input | 1 | 1 = register (8-bit) mode, 0 = pointer (16-bit) mode |
| addr | input | 16 | Access address; low byte only in register mode |
| wr | input | 1 | 1 = write, 0 = read |
| wdata | input | 8 | Write data |
| cfg_we | input | 1 | Write enable for the control register |
| cfg_wdata | input | 8 | Control register value (bit 1 = RAM disable) |
| hi_we | input | 1 | Write enable for the high-address register |
| hi_wdata | input | 8 | High-address register value |
| p2_latch | input | 8 | Current port-2 latch, high byte for external register-mode access |
| rdata | output | 8 | Read data, valid with done |
| done | output | 1 | Access complete pulse |
| ext_p0 | output | 8 | External low address / write data |
| ext_p0_oe | output | 1 | Drive enable for ext_p0 |
| ext_p0_in | input | 8 | External read data |
| ext_p2 | output | 8 | External high address |
| ext_rd_n | output | 1 | External read strobe, active low |
| ext_wr_n | output | 1 | External write strobe, active low |

## Verification
The embedded assertions check the following on every cycle:
- The strobes are never both low.
- Write data is driven whenever the write strobe is low.
- The pins hold still while an on-chip access completes.
- `done` follows an on-chip request by one clock and never lasts two cycles.
- A strobe edge accompanies every external completion.

Only the directed scenarios can show the rest. These cover the data round-trips through the RAM, the 10-bit address built from the high-address register with its upper bits ignored, and the 0x03FF/0x0400 split. They also cover the external address and strobe width, and the re-enable path after the RAM has been disabled.

// File: rtl/xdr_pkg.sv
package xdr_pkg;
    typedef enum logic [1:0] {
        RT_IDLE,
        RT_RAM,
        RT_EXT
    } rt_state_e;

    typedef enum logic [1:0] {
        BM_IDLE,
        BM_SETUP,
        BM_STROBE
    } bm_state_e;
endpackage

// File: rtl/xdr_aux_ram.sv
module xdr_aux_ram #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/xdr_bus_master.sv
module xdr_bus_master
    import xdr_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 8,
    parameter int STRB_CYC = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] p0_in,
    output logic [DW-1:0] p0_out,
    output logic          p0_oe,
    output logic [AW-DW-1:0] p2_out,
    output logic          rd_n,
    output logic          wr_n,
    output logic [DW-1:0] rdata,
    output logic          done
);
    localparam int CW = (STRB_CYC > 1) ? $clog2(STRB_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(STRB_CYC - 1);

    bm_state_e     state;
    logic [CW-1:0] cnt;
    logic          wr_q;
    logic [DW-1:0] wdata_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= BM_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                BM_IDLE:   if (start) state <= BM_SETUP;
                BM_SETUP: begin
                    state <= BM_STROBE;
                    cnt   <= '0;
                end
                BM_STROBE: begin
                    if (cnt == LAST) state <= BM_IDLE;
                    else             cnt   <= cnt + 1'b1;
                end
                default:   state <= BM_IDLE;
            endcase
        end
    end

    // registered pin outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p0_out  <= '0;
            p0_oe   <= 1'b0;
            p2_out  <= '0;
            rd_n    <= 1'b1;
            wr_n    <= 1'b1;
            rdata   <= '0;
            done    <= 1'b0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                BM_IDLE: begin
                    if (start) begin
                        p0_out  <= addr[DW-1:0];
                        p2_out  <= addr[AW-1:DW];
                        p0_oe   <= 1'b1;
                        wr_q    <= wr;
                        wdata_q <= wdata;
                    end
                end
                BM_SETUP: begin
                    if (wr_q) begin
                        p0_out <= wdata_q;
                        wr_n   <= 1'b0;
                    end else begin
                        p0_oe  <= 1'b0;
                        rd_n   <= 1'b0;
                    end
                end
                BM_STROBE: begin
                    if (cnt == LAST) begin
                        rd_n <= 1'b1;
                        wr_n <= 1'b1;
                        if (!wr_q) rdata <= p0_in;
                        done <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n || wr_n));

    // R9
    wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n |-> p0_oe));

    // R8
    done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done |-> ($rose(rd_n) || $rose(wr_n))));
endmodule

// File: rtl/xdata_router.sv
module xdata_router
    import xdr_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int RAM_AW   = 10,
    parameter int STRB_CYC = 3,
    parameter int DIS_BIT  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              use_ri,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              hi_we,
    input  logic [DATA_W-1:0] hi_wdata,
    input  logic [DATA_W-1:0] p2_latch,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic [DATA_W-1:0] ext_p0,
    output logic              ext_p0_oe,
    input  logic [DATA_W-1:0] ext_p0_in,
    output logic [ADDR_W-DATA_W-1:0] ext_p2,
    output logic              ext_rd_n,
    output logic              ext_wr_n
);
    localparam int HI_W = RAM_AW - DATA_W;
    localparam logic [ADDR_W-1:0] RAM_TOP = ADDR_W'((1 << RAM_AW) - 1);

    rt_state_e         state;
    logic [DATA_W-1:0] cfg_q, hi_q;
    logic              ram_en, go, to_ram;
    logic [RAM_AW-1:0] ram_addr;
    logic [DATA_W-1:0] ram_q, bus_rdata;
    logic              bus_done;
    logic [ADDR_W-1:0] ext_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            hi_q  <= '0;
        end else begin
            if (cfg_we) cfg_q <= cfg_wdata;
            if (hi_we)  hi_q  <= hi_wdata;
        end
    end

    always_comb begin
        ram_en   = !cfg_q[DIS_BIT];
        go       = req && (state == RT_IDLE);
        to_ram   = ram_en && (use_ri || (addr <= RAM_TOP));
        ram_addr = use_ri ? {hi_q[HI_W-1:0], addr[DATA_W-1:0]} : addr[RAM_AW-1:0];
        ext_addr = use_ri ? {p2_latch, addr[DATA_W-1:0]} : addr;
    end

    xdr_aux_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
        .clk   (clk),
        .en    (go && to_ram),
        .we    (wr),
        .addr  (ram_addr),
        .wdata (wdata),
        .rdata (ram_q)
    );

    xdr_bus_master #(.AW(ADDR_W), .DW(DATA_W), .STRB_CYC(STRB_CYC)) u_bus (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (go && !to_ram),
        .wr     (wr),
        .addr   (ext_addr),
        .wdata  (wdata),
        .p0_in  (ext_p0_in),
        .p0_out (ext_p0),
        .p0_oe  (ext_p0_oe),
        .p2_out (ext_p2),
        .rd_n   (ext_rd_n),
        .wr_n   (ext_wr_n),
        .rdata  (bus_rdata),
        .done   (bus_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RT_IDLE;
        end else begin
            unique case (state)
                RT_IDLE: if (go) state <= to_ram ? RT_RAM : RT_EXT;
                RT_RAM:  state <= RT_IDLE;
                RT_EXT:  if (bus_done) state <= RT_IDLE;
                default: state <= RT_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        done  = (state == RT_RAM) || bus_done;
        rdata = (state == RT_RAM) ? ram_q : bus_rdata;
    end

    // R7
    ram_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && to_ram |=> done));

    // R3
    ext_not_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !to_ram |=> !done));

    // R6
    pins_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == RT_RAM) |-> ($stable(ext_p0) && $stable(ext_p0_oe) && $stable(ext_p2)
                                && $stable(ext_rd_n) && $stable(ext_wr_n))));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done |=> !done));
endmodule

// File: tb/sim_xdata_router.sv
module sim_xdata_router;
    localparam int STRB = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0, use_ri = 1'b0, wr = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       cfg_we = 1'b0, hi_we = 1'b0;
    logic [7:0] cfg_wdata = '0, hi_wdata = '0, p2_latch = '0;
    logic [7:0] rdata, ext_p0, ext_p2;
    logic [7:0] ext_p0_in = '0;
    logic       done, ext_p0_oe, ext_rd_n, ext_wr_n;

    int total = 0, bad = 0;
    int rd_low = 0, wr_low = 0, oe_bad = 0;
    logic [7:0] seen_wdata = '0;
    logic [7:0] cap_p2, cap_p0;

    always #2 clk = ~clk;

    xdata_router #(.STRB_CYC(STRB)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .use_ri(use_ri), .addr(addr), .wr(wr),
        .wdata(wdata), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .hi_we(hi_we),
        .hi_wdata(hi_wdata), .p2_latch(p2_latch), .rdata(rdata), .done(done),
        .ext_p0(ext_p0), .ext_p0_oe(ext_p0_oe), .ext_p0_in(ext_p0_in), .ext_p2(ext_p2),
        .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n)
    );

    always @(negedge clk) begin
        if (!ext_rd_n) rd_low <= rd_low + 1;
        if (!ext_wr_n) begin
            wr_low <= wr_low + 1;
            seen_wdata <= ext_p0;
            if (!ext_p0_oe) oe_bad <= oe_bad + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic ri, input logic [15:0] a, input logic w,
                       input logic [7:0] d, output logic [7:0] rd, output int cyc,
                       output int rlo, output int wlo, output logic pins_same);
        logic [25:0] snap;
        int r0, w0;
        @(negedge clk);
        snap = {ext_p0, ext_p0_oe, ext_p2, ext_rd_n, ext_wr_n, 7'd0};
        r0 = rd_low; w0 = wr_low;
        req = 1'b1; use_ri = ri; addr = a; wr = w; wdata = d;
        @(negedge clk);
        req = 1'b0;
        cyc = 1;
        cap_p2 = ext_p2; cap_p0 = ext_p0;
        ext_p0_in = ext_p2 ^ ext_p0 ^ 8'h5A;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        rd = rdata;
        pins_same = (snap == {ext_p0, ext_p0_oe, ext_p2, ext_rd_n, ext_wr_n, 7'd0});
        @(negedge clk);
        chk("R10 done pulse width", done, 0);
        rlo = rd_low - r0; wlo = wr_low - w0;
    endtask

    task automatic set_cfg(input logic [7:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic set_hi(input logic [7:0] v);
        @(negedge clk); hi_we = 1'b1; hi_wdata = v;
        @(negedge clk); hi_we = 1'b0;
    endtask

    logic [7:0] rd;
    int cyc, rlo, wlo;
    logic same;

    task automatic t_reset();
        chk("R1 reset done", done, 0);
        chk("R11 reset rd_n", ext_rd_n, 1);
        chk("R11 reset wr_n", ext_wr_n, 1);
        acc(1'b1, 16'h0012, 1'b1, 8'h11, rd, cyc, rlo, wlo, same);
        chk("R1 ri after reset on chip cycles", cyc, 1);
        chk("R1 ri after reset no strobes", rlo + wlo, 0);
    endtask

    task automatic t_dptr_internal();
        acc(1'b0, 16'h0155, 1'b1, 8'hA5, rd, cyc, rlo, wlo, same);
        chk("R7 write done latency", cyc, 1);
        chk("R6 pins quiet on write", same, 1);
        acc(1'b0, 16'h0155, 1'b0, 8'h00, rd, cyc, rlo, wlo, same);
        chk("R2 readback", rd, 8'hA5);
        chk("R7 read done latency", cyc, 1);
        chk("R6 pins quiet on read", same, 1);
        acc(1'b0, 16'h03FF, 1'b1, 8'hC3, rd, cyc, rlo, wlo, same);
        chk("R2 top address on chip", cyc, 1);
        acc(1'b0, 16'h03FF, 1'b0, 8'h00, rd, cyc, rlo, wlo, same);
        chk("R2 top address data", rd, 8'hC3);
    endtask

    task automatic t_ri_internal();
        set_hi(8'hFE);
        acc(1'b1, 16'hFF34, 1'b1, 8'h3C, rd, cyc, rlo, wlo, same);
        chk("R4 ri write on chip", cyc, 1);
        acc(1'b0, 16'h0234, 1'b0, 8'h00, rd, cyc, rlo, wlo, same);
        chk("R4 address hi[1:0]:Ri", rd, 8'h3C);
        set_hi(8'h02);
        acc(1'b1, 16'h0034, 1'b0, 8'h00, rd, cyc, rlo, wlo, same);
        chk("R4 upper hi bits ignored", rd, 8'h3C);
        chk("R6 pins quiet ri", same, 1);
    endtask

    task automatic t_external();
        acc(1'b0, 16'h0400, 1'b0, 8'h00, rd, cyc, rlo, wlo, same);
        chk("R3 0x400 external cycles", cyc, STRB + 2);
        acc(1'b0, 16'h1234, 1'b0, 8'h00, rd, cyc, rlo, wlo, same);
        chk("R8 addr high", cap_p2, 8'h12);
        chk("R8 addr low", cap_p0, 8'h34);
        chk("R8 read strobe width", rlo, STRB);
        chk("R9 no write strobe on read", wlo, 0);
        chk("R8 read data", rd, 8'h12 ^ 8'h34 ^ 8'h5A);
        acc(1'b0, 16'h8001, 1'b1, 8'h77, rd, cyc, rlo, wlo, same);
        chk("R9 write strobe width", wlo, STRB);
        chk("R9 no read strobe on write", rlo, 0);
        chk("R9 write data", seen_wdata, 8'h77);
        chk("R9 p0 driven in write", oe_bad, 0);
        chk("R8 write cycles", cyc, STRB + 2);
    endtask

    task automatic t_disabled();
        set_cfg(8'h02);
        p2_latch = 8'hAB;
        acc(1'b1, 16'h0010, 1'b0, 8'h00, rd, cyc, rlo, wlo, same);
        chk("R5 ri external cycles", cyc, STRB + 2);
        chk("R5 ri high byte from latch", cap_p2, 8'hAB);
        chk("R5 ri low byte", cap_p0, 8'h10);
        acc(1'b0, 16'h0155, 1'b0, 8'h00, rd, cyc, rlo, wlo, same);
        chk("R5 dptr external when disabled", rlo, STRB);
        chk("R5 external data", rd, 8'h01 ^ 8'h55 ^ 8'h5A);
        set_cfg(8'h00);
        acc(1'b0, 16'h0155, 1'b0, 8'h00, rd, cyc, rlo, wlo, same);
        chk("R5 re-enabled contents", rd, 8'hA5);
        chk("R5 re-enabled on chip", cyc, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dptr_internal();
        t_ri_internal();
        t_external();
        t_disabled();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule